// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the register-level control of an on-chip successive-approximation analog-to-digital converter. Software uses a small write/read bus to set an enable bit (which powers the converter into standby) and a start bit (which launches one conversion). It also uses the bus to pick an input channel and to read back the result. The analog comparator, the sample-and-hold stage and the DAC sit outside the block and appear only as ports. The block drives the DAC trial code, the channel select and a sample strobe, and it reads a single comparator bit.

A conversion takes one sample cycle followed by one decision cycle per result bit, deciding from the most significant bit down. When the last bit is decided, the result is stored, a one-cycle interrupt pulse is raised, and the start bit clears itself. Software can abandon a conversion by clearing start or enable. An abandoned conversion leaves the previous result and raises no interrupt. The settling wait after enabling is software's job and is not enforced here.

Register map (address on `bus_addr`, reads are combinational and zero-extended): 0 = control (bit 1 enable, bit 0 start), 1 = channel (low CH_W bits), 2 = full result, 3 = upper 8 result bits.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, control, channel and result all read 0, and `irq_o`, `busy_o` and `sample_o` are low.
- R2: A write of control with bit 1 set from the stop state enters standby, and control then reads 2.
- R3: A write of 3 to control while already in standby starts a conversion at that clock edge. `sample_o` is high for the next cycle, and RES_W decision cycles follow. In each decision cycle `dac_code_o` holds the bits decided so far plus the current bit, starting with 1<<(RES_W-1).
- R4: In each decision cycle a comparator value of 1 keeps the trial bit. When the conversion completes, address 2 reads the decided code, address 3 reads its bits [9:2], and `irq_o` is high for exactly one cycle. That cycle is the (RES_W+1)th cycle after the start edge.
- R5: On completion the start bit clears itself, `busy_o` falls, and control reads 2.
- R6: Writing 2 to control during a conversion, including during its last decision cycle, abandons the conversion and returns to standby. No result is stored and no interrupt is raised.
- R7: Writing 0 to control in standby returns to stop, and control reads 0.
- R8: A start request while enable is 0 is dropped. A write of 1 stays in stop. A write of 3 from stop sets only enable. In both cases control reads back start as 0 and no conversion begins.
- R9: `chan_sel_o` is the channel captured at the start edge. Rewriting the channel during a conversion changes only the next conversion.
- R10: The result register keeps its value until the next completed conversion.
- R11: Writing 0 to control during a conversion abandons it without result or interrupt and enters stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| dac_code_o | output | 10 | Trial code to the DAC |
| sample_o | output | 1 | Sample-and-hold strobe |
| chan_sel_o | output | 3 | Latched analog channel select |
| busy_o | output | 1 | Conversion in progress |
| irq_o | output | 1 | End-of-conversion pulse |

## Verification
The assertions check several invariants on every cycle. Start is never set without enable, and start always matches the sequencer's busy state. The interrupt never lasts two cycles, and it never coincides with start. The result changes only together with an interrupt. The latched channel is frozen while busy. The sample cycle always leads into the MSB trial, and the trial code never carries bits below the current position. Only the bench scenarios can show the rest, by driving a comparator from a chosen analog level. These cover the correct final code and the exact interrupt cycle, abandonment on the last decision cycle, dropped start requests, and the effect of a mid-conversion channel rewrite on the following conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SAMP = 2'd1,
        PH_CONV = 2'd2
    } sar_phase_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CHAN = 2'd1;
    localparam logic [1:0] ADDR_RES  = 2'd2;
    localparam logic [1:0] ADDR_RESH = 2'd3;

    localparam int CTRL_EN_BIT = 1;
    localparam int CTRL_GO_BIT = 0;
endpackage

// File: rtl/adc_seq_sar.sv
module adc_seq_sar
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             begin_i,
    input  logic             abort_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic             sample_o,
    output logic [RES_W-1:0] dac_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o
);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

    typedef struct packed {
        sar_phase_e       ph;
        logic [IDX_W-1:0] idx;
        logic [RES_W-1:0] work;
    } sar_t;

    sar_t s_d, s_q;
    logic [RES_W-1:0] trial;

    always_comb begin
        trial  = s_q.work | (RES_W'(1) << s_q.idx);
        s_d    = s_q;
        done_o = 1'b0;
        case (s_q.ph)
            PH_IDLE: if (begin_i) s_d.ph = PH_SAMP;
            PH_SAMP: begin
                s_d.ph   = PH_CONV;
                s_d.idx  = TOP_IDX;
                s_d.work = '0;
            end
            PH_CONV: begin
                if (cmp_i) s_d.work = trial;
                if (s_q.idx == '0) begin
                    s_d.ph = PH_IDLE;
                    done_o = 1'b1;
                end else begin
                    s_d.idx = s_q.idx - 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
        if (abort_i) begin
            s_d.ph = PH_IDLE;
            done_o = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, idx: '0, work: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o   = (s_q.ph != PH_IDLE);
    assign sample_o = (s_q.ph == PH_SAMP);
    assign dac_o    = (s_q.ph == PH_CONV) ? trial : '0;
    assign result_o = cmp_i ? trial : s_q.work;

    // R3: the sample cycle leads into the MSB trial
    assert_samp_to_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_SAMP && !abort_i) |=> (s_q.ph == PH_CONV && dac_o == (RES_W'(1) << TOP_IDX)));

    // R3: no bits below the current trial position are set in the DAC code
    assert_dac_low_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_CONV) |-> ((dac_o & ((RES_W'(1) << s_q.idx) - RES_W'(1))) == '0));

    // R4: a decision cycle that is not the last continues converting
    assert_conv_continues_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_CONV && s_q.idx != '0 && !abort_i) |=> (s_q.ph == PH_CONV));
endmodule

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl #(
    parameter int RES_W = 10,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl_i,
    input  logic             wr_chan_i,
    input  logic             en_i,
    input  logic             go_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic             sar_done_i,
    input  logic [RES_W-1:0] sar_result_i,
    output logic             enable_o,
    output logic             start_o,
    output logic [CH_W-1:0]  chan_o,
    output logic [CH_W-1:0]  chan_lat_o,
    output logic [RES_W-1:0] result_o,
    output logic             irq_o,
    output logic             begin_o,
    output logic             abort_o
);
    typedef struct packed {
        logic             en;
        logic             go;
        logic [CH_W-1:0]  chan;
        logic [CH_W-1:0]  chan_lat;
        logic [RES_W-1:0] result;
        logic             irq;
    } ctl_t;

    ctl_t c_d, c_q;
    logic go_new;

    always_comb begin
        go_new  = en_i & go_i & c_q.en;
        begin_o = wr_ctrl_i & go_new & ~c_q.go;
        abort_o = wr_ctrl_i & c_q.go & ~go_new;

        c_d     = c_q;
        c_d.irq = 1'b0;
        if (wr_ctrl_i) begin
            c_d.en = en_i;
            c_d.go = go_new;
        end
        if (wr_chan_i) c_d.chan = chan_i;
        if (begin_o)   c_d.chan_lat = c_q.chan;
        if (sar_done_i) begin
            c_d.go     = 1'b0;
            c_d.result = sar_result_i;
            c_d.irq    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign enable_o   = c_q.en;
    assign start_o    = c_q.go;
    assign chan_o     = c_q.chan;
    assign chan_lat_o = c_q.chan_lat;
    assign result_o   = c_q.result;
    assign irq_o      = c_q.irq;

    // R8: start is never held without enable
    assert_go_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.go |-> c_q.en);

    // R4: the interrupt is a single-cycle pulse
    assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.irq |=> !c_q.irq);

    // R5: start is already clear while the interrupt is shown
    assert_irq_go_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.irq |-> !c_q.go);

    // R10: the result changes only together with a completion
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (c_q.irq || $stable(c_q.result)));

    // R9: the latched channel is frozen while a conversion runs
    assert_chan_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.go |=> (!c_q.go || $stable(c_q.chan_lat)));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int CH_W   = 3,
    parameter int DATA_W = 16,
    parameter int HI_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cmp_i,
    output logic [RES_W-1:0]  dac_code_o,
    output logic              sample_o,
    output logic [CH_W-1:0]   chan_sel_o,
    output logic              busy_o,
    output logic              irq_o
);
    logic             wr_ctrl, wr_chan;
    logic             enable_q, start_q;
    logic [CH_W-1:0]  chan_q;
    logic [RES_W-1:0] result_q;
    logic             begin_s, abort_s;
    logic             sar_busy, sar_done;
    logic [RES_W-1:0] sar_result;
    logic             unused_wdata;

    assign wr_ctrl      = bus_we && (bus_addr == ADDR_CTRL);
    assign wr_chan      = bus_we && (bus_addr == ADDR_CHAN);
    assign unused_wdata = ^bus_wdata;

    adc_seq_ctl #(.RES_W(RES_W), .CH_W(CH_W)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_ctrl_i    (wr_ctrl),
        .wr_chan_i    (wr_chan),
        .en_i         (bus_wdata[CTRL_EN_BIT]),
        .go_i         (bus_wdata[CTRL_GO_BIT]),
        .chan_i       (bus_wdata[CH_W-1:0]),
        .sar_done_i   (sar_done),
        .sar_result_i (sar_result),
        .enable_o     (enable_q),
        .start_o      (start_q),
        .chan_o       (chan_q),
        .chan_lat_o   (chan_sel_o),
        .result_o     (result_q),
        .irq_o        (irq_o),
        .begin_o      (begin_s),
        .abort_o      (abort_s)
    );

    adc_seq_sar #(.RES_W(RES_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .begin_i  (begin_s),
        .abort_i  (abort_s),
        .cmp_i    (cmp_i),
        .busy_o   (sar_busy),
        .sample_o (sample_o),
        .dac_o    (dac_code_o),
        .done_o   (sar_done),
        .result_o (sar_result)
    );

    assign busy_o = sar_busy;

    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = DATA_W'({enable_q, start_q});
            ADDR_CHAN: bus_rdata = DATA_W'(chan_q);
            ADDR_RES:  bus_rdata = DATA_W'(result_q);
            default:   bus_rdata = DATA_W'(result_q[RES_W-1 -: HI_W]);
        endcase
    end

    // R5: the start bit tracks the sequencer's busy state exactly
    assert_start_eq_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_q == sar_busy);

    // R8: a control write with enable 0 never leaves start set
    assert_drop_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !bus_wdata[CTRL_EN_BIT]) |=> !start_q);

    // R11: clearing enable stops any running conversion
    assert_disable_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !bus_wdata[CTRL_EN_BIT]) |=> (!busy_o && !enable_q));
endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
    localparam int RES_W = 10;
    localparam int CH_W  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        cmp;
    logic [9:0]  dac;
    logic        sample, busy, irq;
    logic [2:0]  chan_sel;
    logic [9:0]  ana = 10'd0;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    assign cmp = (ana >= dac);

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_i(cmp),
        .dac_code_o(dac), .sample_o(sample), .chan_sel_o(chan_sel),
        .busy_o(busy), .irq_o(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = 16'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    function automatic int exp_hi(input int r);
        return (r >> (RES_W - 8)) & 8'hFF;
    endfunction

    function automatic int exp_dac2(input int a);
        return ((a >= 512) ? 512 : 0) | 256;
    endfunction

    int exp_result = 0;

    // Runs a conversion from standby. abort_at: 0 none, else the edge index j
    // after the start edge at which a control write of abort_val lands.
    // chan_at: edge at which channel new_ch is written (0 none).
    task automatic run_conv(input int a, input int abort_at, input int abort_val,
                            input int chan_at, input int new_ch, input int lat_ch);
        int v;
        int irqs = 0;
        bit aborted;
        ana = 10'(a);
        aborted = (abort_at >= 1) && (abort_at <= RES_W + 1);
        wr(2'd0, 3);
        check("R3 sample", int'(sample), 1);
        check("R9 chan latch", int'(chan_sel), lat_ch);
        for (int j = 1; j <= RES_W + 2; j++) begin
            if (j == abort_at) begin
                bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 16'(abort_val);
            end else if (j == chan_at) begin
                bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 16'(new_ch);
            end else begin
                bus_we = 1'b0;
            end
            @(negedge clk);
            bus_we = 1'b0;
            if (irq) irqs++;
            if (j == 1 && abort_at != 1) check("R3 msb trial", int'(dac), 512);
            if (j == 2 && abort_at > 2) check("R3 second trial", int'(dac), exp_dac2(a));
            if (j == RES_W + 1) check("R4 irq cycle", int'(irq), aborted ? 0 : 1);
            if (j < RES_W + 1 && (abort_at == 0 || j < abort_at))
                check("R9 chan held", int'(chan_sel), lat_ch);
        end
        if (!aborted) exp_result = a;
        check(aborted ? "R6 irq count" : "R4 irq count", irqs, aborted ? 0 : 1);
        check("R5 busy low", int'(busy), 0);
        rd(2'd2, v); check(aborted ? "R10 result kept" : "R4 result", v, exp_result);
        rd(2'd3, v); check("R4 upper result", v, exp_hi(exp_result));
        rd(2'd0, v);
        check(abort_at != 0 && abort_val == 0 ? "R11 ctrl" : "R5 ctrl", v,
              abort_at != 0 ? abort_val : 2);
    endtask

    initial begin
        int v;
        int cur_ch;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 0);
        rd(2'd1, v); check("R1 chan", v, 0);
        rd(2'd2, v); check("R1 result", v, 0);
        check("R1 irq", int'(irq), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 sample", int'(sample), 0);

        // R8 dropped start requests
        wr(2'd0, 1);
        rd(2'd0, v); check("R8 go alone", v, 0);
        check("R8 no busy", int'(busy), 0);
        wr(2'd0, 3);
        rd(2'd0, v); check("R8 go with en from stop", v, 2);
        check("R8 no busy 2", int'(busy), 0);
        // R7 back to stop
        wr(2'd0, 0);
        rd(2'd0, v); check("R7 stop", v, 0);
        // R2 enable
        wr(2'd0, 2);
        rd(2'd0, v); check("R2 standby", v, 2);

        // Directed conversion with a channel rewrite in flight (R3 R4 R9)
        wr(2'd1, 5);
        run_conv(10'h2A5, 0, 0, 3, 2, 5);
        rd(2'd1, v); check("R9 chan reg", v, 2);
        // Next conversion uses the rewritten channel; all-ones and zero codes
        run_conv(1023, 0, 0, 0, 0, 2);
        run_conv(0, 0, 0, 0, 0, 2);
        run_conv(10'h155, 0, 0, 0, 0, 2);
        // R6 abort on the last decision cycle
        run_conv(10'h3C3, RES_W + 1, 2, 0, 0, 2);
        // R6 abort early
        run_conv(10'h0F0, 1, 2, 0, 0, 2);
        // R11 disable mid conversion
        run_conv(10'h111, 4, 0, 0, 0, 2);
        wr(2'd0, 2);

        // Random mix
        cur_ch = 2;
        for (int it = 0; it < 60; it++) begin
            int a, ab, abv, ca, nc;
            a   = int'($urandom_range(0, 1023));
            ab  = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, RES_W + 2)) : 0;
            abv = ($urandom_range(0, 1) == 0) ? 0 : 2;
            ca  = ($urandom_range(0, 1) == 0) ? int'($urandom_range(1, RES_W)) : 0;
            if (ca == ab) ca = 0;
            nc  = int'($urandom_range(0, 7));
            run_conv(a, ab, abv, ca, nc, cur_ch);
            if (ca != 0) cur_ch = nc;
            if (ab != 0 && abv == 0) wr(2'd0, 2);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule